// File: doc/BRIEF.md
# Key-Guarded Alternate Function Select

This block protects the per-line alternate-function select bits of an I/O port from accidental change. It owns three registers on a simple single-cycle register bus: a lock, a commit mask and the alternate-select register itself. The committed alternate-select bits drive the pin routing logic directly through `alt_sel`.

Software opens the lock by writing a fixed 32-bit key. While it is open, exactly one write to the commit-mask register is accepted. That write, and any commit-mask write made while locked, closes the lock again. The commit mask then filters every write to the alternate-select register bit by bit. Bits whose mask bit is set take the written value. Bits whose mask bit is clear silently keep their old value.

The bus has no handshake. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. Addresses are byte offsets and are decoded in full, so an address that is off by any low bit matches no register.

Top module: `alt_select_guard`

## Requirements
- R1: After reset the lock reads 1 (locked), the commit mask reads all ones over the line bits, and the alternate-select register and `alt_sel` read all zeros.
- R2: A write of exactly 0x4C4F434B to offset 0x520 opens the lock, which then reads 0 at offset 0x520 (bit 0; upper bits read 0).
- R3: A write of any other value to offset 0x520 leaves the lock closed, reading 1.
- R4: A write to the commit mask (offset 0x524) while the lock is closed leaves the mask unchanged.
- R5: A write to the commit mask while the lock is open stores the low NUM_LINES bits of the write data.
- R6: Every write to offset 0x524 leaves the lock closed afterwards, whether or not the mask was updated.
- R7: A write to offset 0x420 updates each alternate-select bit whose commit-mask bit is 1 and keeps each bit whose commit-mask bit is 0.
- R8: `alt_sel` always equals the stored alternate-select value, and the stored value changes only on a write to offset 0x420.
- R9: Reads of offsets 0x524 and 0x420 return the stored value zero-extended. Reads of any other offset return 0. Writes to any other offset, including the key value, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| alt_sel | output | NUM_LINES | Committed alternate-function select, one bit per line |

## Verification
An accepted commit-mask update and the forced relock fall on the same clock edge, because both come from the same write. The bench provokes this by writing the key and then a commit-mask value on the next cycle. It then reads back both registers. The mask must hold the new value and the lock must read 1. A second commit-mask write with a different value must then leave the mask alone. Random sequences also mix key writes with commit and alternate-select writes, so this coincidence recurs under varied masks.

// File: rtl/alt_guard_pkg.sv
package alt_guard_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ALT    = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LOCK,
        SEL_COMMIT,
        SEL_ALT
    } reg_sel_e;

    typedef struct packed {
        logic lock;
        logic commit;
        logic alt;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == OFS_LOCK)        return SEL_LOCK;
        else if (a == OFS_COMMIT) return SEL_COMMIT;
        else if (a == OFS_ALT)    return SEL_ALT;
        else                      return SEL_NONE;
    endfunction

    function automatic logic is_key(input logic [DATA_W-1:0] d);
        return d == UNLOCK_KEY;
    endfunction

endpackage

// File: rtl/agd_decode.sv
module agd_decode
    import alt_guard_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output wr_strobe_t        strobe
);
    always_comb begin
        sel           = decode_addr(addr);
        strobe.lock   = wr && (sel == SEL_LOCK);
        strobe.commit = wr && (sel == SEL_COMMIT);
        strobe.alt    = wr && (sel == SEL_ALT);
    end
endmodule

// File: rtl/agd_key_lock.sv
module agd_key_lock
    import alt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lock,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b1;
        else if (wr_lock)
            locked <= !is_key(wdata);
        else if (wr_commit)
            locked <= 1'b1;
    end
endmodule

// File: rtl/agd_commit_mask.sv
module agd_commit_mask #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_commit,
    input  logic                 locked,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (wr_commit && !locked)
            mask <= wdata;
    end
endmodule

// File: rtl/agd_alt_select.sv
module agd_alt_select #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_alt,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] alt_q
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                alt_q[i] <= 1'b0;
            else if (wr_alt && mask[i])
                alt_q[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/alt_select_guard.sv
module alt_select_guard
    import alt_guard_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] alt_sel
);
    reg_sel_e             sel;
    wr_strobe_t           strobe;
    logic                 locked;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] alt_q;

    agd_decode u_decode (
        .wr     (bus_wr),
        .addr   (bus_addr),
        .sel    (sel),
        .strobe (strobe)
    );

    agd_key_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .wr_lock   (strobe.lock),
        .wr_commit (strobe.commit),
        .wdata     (bus_wdata),
        .locked    (locked)
    );

    agd_commit_mask #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .wr_commit (strobe.commit),
        .locked    (locked),
        .wdata     (bus_wdata[NUM_LINES-1:0]),
        .mask      (mask)
    );

    agd_alt_select #(.NUM_LINES(NUM_LINES)) u_alt (
        .clk    (clk),
        .rst    (rst),
        .wr_alt (strobe.alt),
        .mask   (mask),
        .wdata  (bus_wdata[NUM_LINES-1:0]),
        .alt_q  (alt_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_LOCK:   bus_rdata[0]           = locked;
            SEL_COMMIT: bus_rdata[NUM_LINES-1:0] = mask;
            SEL_ALT:    bus_rdata[NUM_LINES-1:0] = alt_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign alt_sel = alt_q;
endmodule

// File: rtl/alt_select_guard_chk.sv
module alt_select_guard_chk
    import alt_guard_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 locked,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] alt_sel
);
    // R2
    key_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked);

    // R4
    locked_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_COMMIT && locked) |=> $stable(mask));

    // R6
    commit_relocks_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_COMMIT) |=> locked);

    // R7
    uncommitted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_ALT) |=>
        ((alt_sel & ~$past(mask)) == ($past(alt_sel) & ~$past(mask))));

    // R8
    alt_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_ALT) |=> $stable(alt_sel));
endmodule

bind alt_select_guard alt_select_guard_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .locked    (locked),
    .mask      (mask),
    .alt_sel   (alt_sel)
);

// File: tb/alt_select_guard_bench.sv
`timescale 1ns/100ps
module alt_select_guard_bench;
    import alt_guard_pkg::*;

    localparam int LINES = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic [LINES-1:0]  alt_sel;

    int checks = 0;
    int fails  = 0;

    logic             m_locked;
    logic [LINES-1:0] m_mask;
    logic [LINES-1:0] m_alt;

    always #2.5 clk = ~clk;

    alt_select_guard #(.NUM_LINES(LINES)) u_alt_select_guard (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alt_sel   (alt_sel)
    );

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        if (a == 12'h520)      return {31'b0, m_locked};
        else if (a == 12'h524) return 32'(m_mask);
        else if (a == 12'h420) return 32'(m_alt);
        else                   return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a == 12'h520) begin
            m_locked = (d != 32'h4C4F434B);
        end else if (a == 12'h524) begin
            if (!m_locked) m_mask = d[LINES-1:0];
            m_locked = 1'b1;
        end else if (a == 12'h420) begin
            m_alt = (d[LINES-1:0] & m_mask) | (m_alt & ~m_mask);
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic check_all(input string req);
        do_read(12'h520, req);
        do_read(12'h524, req);
        do_read(12'h420, req);
        check({req, " alt_sel"}, 32'(alt_sel), 32'(m_alt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        m_locked = 1'b1; m_mask = '1; m_alt = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        check_all("R1 reset");

        // R7 with full mask from reset
        do_write(12'h420, 32'h0000_00A5);
        check_all("R7 full mask");

        // R4: commit write while locked ignored; R6 stays locked
        do_write(12'h524, 32'h0000_000F);
        check_all("R4 locked commit");

        // R3: wrong key
        do_write(12'h520, 32'h4C4F434A);
        check_all("R3 wrong key");

        // R2: key opens
        do_write(12'h520, 32'h4C4F434B);
        check_all("R2 unlock");

        // R5 + R6 same edge
        do_write(12'h524, 32'hFFFF_FF0F);
        check_all("R5 R6 accepted commit");
        do_write(12'h524, 32'h0000_00FF);
        check_all("R6 relocked then R4");

        // R7: partial mask merge
        do_write(12'h420, 32'h0000_005A);
        check_all("R7 partial mask");

        // R3: unlock then relock with other value
        do_write(12'h520, 32'h4C4F434B);
        do_write(12'h520, 32'h0000_0000);
        do_write(12'h524, 32'h0000_0000);
        check_all("R3 relock by value");

        // R9: unmapped offsets
        do_write(12'h521, 32'h4C4F434B);
        do_write(12'h528, 32'hFFFF_FFFF);
        do_write(12'h421, 32'hFFFF_FFFF);
        do_read(12'h000, "R9 unmapped 000");
        do_read(12'h521, "R9 unmapped 521");
        check_all("R9 no effect");

        // R8 and random mix
        for (int i = 0; i < 400; i++) begin
            int pick;
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            pick = $urandom_range(0, 4);
            d = $urandom;
            case (pick)
                0: begin a = 12'h520; if ($urandom_range(0, 1) == 1) d = 32'h4C4F434B; end
                1: a = 12'h524;
                2: a = 12'h420;
                3: a = 12'h420;
                default: a = 12'h100;
            endcase
            do_write(a, d);
            check_all("R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule